// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two component predictors of different character. The first is a table of 2-bit saturating counters indexed only by low program-counter bits. It learns strongly biased branches within a few executions, because every execution of a branch trains the same counter. The second is a table of the same counters indexed by the XOR of low program-counter bits and a global outcome history register. It captures branches whose direction depends on the recent path, but it spreads one branch's training over several entries and so re-learns more slowly.

A third table of 2-bit counters, the chooser, is indexed by the program counter. For each branch it records which component has been right more often and picks that component's answer. The prediction side is purely combinational: a PC goes in and a direction and a source flag come out in the same cycle. The update side takes the resolved PC and outcome and trains all three tables and the history register at the next clock edge. A flush input returns every table and the history to the reset state, which models the loss of predictor state on a context switch. Until the correlating side proves itself again, the chooser then trusts the bimodal side.

Top module: `tourn_pred`

## Requirements
- R1: After reset, every PC predicts not-taken (`pred_taken`=0) and reports the bimodal source (`pred_src`=0). All component counters start at 1 (weakly not-taken) and all chooser counters start at 1 (weakly bimodal).
- R2: Each bimodal and correlating counter holds 0..3 and predicts taken when its value is 2 or 3. An update with outcome taken raises the indexed counter by one, saturating at 3. An outcome of not-taken lowers it by one, saturating at 0.
- R3: The bimodal and chooser index is `upd_pc`/`pred_pc` bits [IDX_W-1:0]. The correlating index is those bits XOR the global history zero-extended to IDX_W. Each accepted update shifts the history left by one and puts the outcome (1 = taken) in bit 0.
- R4: The chooser counter of the updated PC changes only when the two components' predictions for that update disagree. It rises by one (saturating at 3) when the correlating side was correct and falls by one (saturating at 0) when the bimodal side was correct.
- R5: When the chooser counter's bit 1 is set, `pred_src`=1 and `pred_taken` is the correlating prediction. Otherwise `pred_src`=0 and `pred_taken` is the bimodal prediction.
- R6: `flush` restores every counter and the history to the R1 state at the next edge and takes priority over a simultaneous update.
- R7: The prediction is combinational in `pred_pc`. An update affects predictions from the cycle after its clock edge onward, and a prediction in the same cycle as an update sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all predictor state at the next edge |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_src | output | 1 | 1 = correlating component chosen, 0 = bimodal |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A wrong counter, history bit or chooser entry stays hidden until the PC that maps to it is predicted. It then shows as a flipped `pred_taken` or `pred_src` in that same cycle. A history error shows as a wrong correlating index, which appears only once the affected entry disagrees with the bimodal one. Continuous prediction of random PCs against a full reference model exposes such errors within a few cycles of their origin. A broken flush or reset shows at once, as a taken prediction or a correlating source on a PC that has not been trained.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_LO = 2'b01;

    typedef enum logic {
        SRC_BIMODAL = 1'b0,
        SRC_CORREL  = 1'b1
    } src_e;

    typedef struct packed {
        logic bim_dir;
        logic cor_dir;
        logic use_cor;
    } comp_view_t;

    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        else    return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tourn_ctr_table.sv
module tourn_ctr_table
    import tourn_pkg::*;
#(
    parameter int   IDX_W   = 6,
    parameter ctr2_t RST_VAL = CTR_WEAK_LO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output ctr2_t            up_ctr,
    input  logic             up_en,
    input  logic             up_dir
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t [DEPTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= {DEPTH{RST_VAL}};
        end else if (up_en) begin
            cnt[up_idx] <= ctr_step(cnt[up_idx], up_dir);
        end
    end

    assign rd_ctr = cnt[rd_idx];
    assign up_ctr = cnt[up_idx];

    // R2: a trained counter moves by at most one step per cycle
    p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt[$past(up_idx)] - $past(cnt[up_idx])) != 2'd2);

    // R2: saturation at the top, no wrap to zero
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (up_en && !clr && up_dir && cnt[up_idx] == 2'd3) |=> cnt[$past(up_idx)] == 2'd3);

    // R4: entries are untouched when this table is not trained
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!up_en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/tourn_ghist.sv
module tourn_ghist #(
    parameter int GH_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [GH_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[GH_W-2:0], bit_in};
        end
    end

    // R3: newest outcome lands in bit 0, older bits move up
    p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (hist[0] == $past(bit_in)) &&
                               (hist[GH_W-1:1] == $past(hist[GH_W-2:0])));

    // R6: flush empties the history
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> hist == '0);

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tourn_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IDX_W = 6,
    parameter int GH_W  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_src,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int PAD_W = IDX_W - GH_W;

    logic [GH_W-1:0]  ghist;
    logic [IDX_W-1:0] gh_ext;
    logic [IDX_W-1:0] p_base, p_cor, u_base, u_cor;
    ctr2_t            p_bim_c, p_cor_c, p_sel_c;
    ctr2_t            u_bim_c, u_cor_c, u_sel_c;
    comp_view_t       pv, uv;
    src_e             src;
    logic             upd_go, sel_go, sel_up;

    generate
        if (PAD_W > 0) begin : g_pad
            assign gh_ext = {{PAD_W{1'b0}}, ghist};
        end else begin : g_nopad
            assign gh_ext = ghist[IDX_W-1:0];
        end
    endgenerate

    assign p_base = pred_pc[IDX_W-1:0];
    assign u_base = upd_pc[IDX_W-1:0];
    assign p_cor  = p_base ^ gh_ext;
    assign u_cor  = u_base ^ gh_ext;

    assign upd_go = upd_valid && !flush;

    tourn_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) i_bim (
        .clk(clk), .rst(rst), .clr(flush),
        .rd_idx(p_base), .rd_ctr(p_bim_c),
        .up_idx(u_base), .up_ctr(u_bim_c),
        .up_en(upd_go), .up_dir(upd_taken)
    );

    tourn_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) i_cor (
        .clk(clk), .rst(rst), .clr(flush),
        .rd_idx(p_cor), .rd_ctr(p_cor_c),
        .up_idx(u_cor), .up_ctr(u_cor_c),
        .up_en(upd_go), .up_dir(upd_taken)
    );

    always_comb begin
        uv.bim_dir = ctr_dir(u_bim_c);
        uv.cor_dir = ctr_dir(u_cor_c);
        uv.use_cor = ctr_dir(u_sel_c);
        sel_go     = upd_go && (uv.bim_dir != uv.cor_dir);
        sel_up     = (uv.cor_dir == upd_taken);
    end

    tourn_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) i_sel (
        .clk(clk), .rst(rst), .clr(flush),
        .rd_idx(p_base), .rd_ctr(p_sel_c),
        .up_idx(u_base), .up_ctr(u_sel_c),
        .up_en(sel_go), .up_dir(sel_up)
    );

    tourn_ghist #(.GH_W(GH_W)) i_gh (
        .clk(clk), .rst(rst), .clr(flush),
        .shift_en(upd_go), .bit_in(upd_taken),
        .hist(ghist)
    );

    always_comb begin
        pv.bim_dir = ctr_dir(p_bim_c);
        pv.cor_dir = ctr_dir(p_cor_c);
        pv.use_cor = ctr_dir(p_sel_c);
        src        = pv.use_cor ? SRC_CORREL : SRC_BIMODAL;
        pred_taken = (src == SRC_CORREL) ? pv.cor_dir : pv.bim_dir;
        pred_src   = src;
    end

    // R6: after a flush nothing is trusted to the correlating side
    p_flush_bimodal_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> !pred_src && !pred_taken);

    // R1: first cycle after reset predicts not-taken from the bimodal side
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> !pred_src && !pred_taken);

    initial begin
        a_hist_fits_r3: assert (GH_W >= 2 && GH_W <= IDX_W);
    end

endmodule

// File: tb/test_tourn_pred.sv
module test_tourn_pred;
    localparam int PC_W  = 16;
    localparam int IDX_W = 6;
    localparam int GH_W  = 6;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            flush = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken, pred_src;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0]      m_bim [DEPTH];
    logic [1:0]      m_cor [DEPTH];
    logic [1:0]      m_sel [DEPTH];
    logic [GH_W-1:0] m_gh;

    always #5 clk = ~clk;

    tourn_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .GH_W(GH_W)) i_tourn_pred (
        .clk(clk), .rst(rst), .flush(flush),
        .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_src(pred_src),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic [IDX_W-1:0] cidx(logic [PC_W-1:0] pc);
        return pc[IDX_W-1:0] ^ IDX_W'(m_gh);
    endfunction

    function automatic logic exp_src(logic [PC_W-1:0] pc);
        return m_sel[pc[IDX_W-1:0]][1];
    endfunction

    function automatic logic exp_dir(logic [PC_W-1:0] pc);
        return exp_src(pc) ? m_cor[cidx(pc)][1] : m_bim[pc[IDX_W-1:0]][1];
    endfunction

    task automatic m_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_bim[i] = 2'd1; m_cor[i] = 2'd1; m_sel[i] = 2'd1;
        end
        m_gh = '0;
    endtask

    task automatic m_update(logic [PC_W-1:0] pc, logic t);
        logic [IDX_W-1:0] b, c;
        logic bd, cd;
        b  = pc[IDX_W-1:0];
        c  = cidx(pc);
        bd = m_bim[b][1];
        cd = m_cor[c][1];
        if (bd != cd) m_sel[b] = sat(m_sel[b], cd == t);
        m_bim[b] = sat(m_bim[b], t);
        m_cor[c] = sat(m_cor[c], t);
        m_gh = {m_gh[GH_W-2:0], t};
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare the combinational prediction, clock, mirror state
    task automatic cyc(string req, logic [PC_W-1:0] ppc, logic uv,
                       logic [PC_W-1:0] upc, logic ut, logic fl);
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut; flush = fl;
        #1;
        chk(req, "pred_taken", pred_taken, exp_dir(ppc));
        chk(req, "pred_src", pred_src, exp_src(ppc));
        @(posedge clk);
        #1;
        if (fl) m_clear();
        else if (uv) m_update(upc, ut);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pc;
        void'($urandom(32'h5EED_1234));
        m_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports for several PCs
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pred_pc = PC_W'(k * 11 + 3);
            #1;
            chk("R1", "reset pred_taken", pred_taken, 1'b0);
            chk("R1", "reset pred_src", pred_src, 1'b0);
        end

        // R2 and R7: bias one branch to taken, then saturation and step down
        pc = 16'h0005;
        cyc("R7", pc, 1'b1, pc, 1'b1, 1'b0);
        @(negedge clk); pred_pc = pc; #1;
        chk("R7", "visible next cycle", pred_taken, 1'b1);
        for (int k = 0; k < 4; k++) cyc("R2", pc, 1'b1, pc, 1'b1, 1'b0);
        cyc("R2", pc, 1'b1, pc, 1'b0, 1'b0);
        cyc("R2", pc, 1'b1, pc, 1'b0, 1'b0);
        cyc("R2", pc, 1'b1, pc, 1'b0, 1'b0);
        cyc("R2", pc, 1'b0, pc, 1'b0, 1'b0);

        // R3 and R4: alternating branch; history separates its entries
        pc = 16'h0021;
        for (int k = 0; k < 40; k++) cyc("R3", pc, 1'b1, pc, k[0], 1'b0);
        cyc("R4", pc, 1'b0, pc, 1'b0, 1'b0);
        @(negedge clk); pred_pc = pc; #1;
        chk("R5", "alternating branch uses correlating side", pred_src, 1'b1);

        // R6: flush with a simultaneous update
        cyc("R6", pc, 1'b1, pc, 1'b1, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            pred_pc = PC_W'(16'h0021 + k * 5);
            upd_valid = 1'b0; flush = 1'b0;
            #1;
            chk("R6", "flushed pred_taken", pred_taken, 1'b0);
            chk("R6", "flushed pred_src", pred_src, 1'b0);
        end

        // random traffic: a few hot branches with biased or patterned outcomes
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] up, pp;
            logic t;
            int sel;
            sel = $urandom_range(0, 7);
            up  = PC_W'(sel * 7 + 2);
            case (sel % 3)
                0: t = ($urandom_range(0, 9) != 0);
                1: t = m_gh[1];
                default: t = $urandom_range(0, 1) != 0;
            endcase
            pp = ($urandom_range(0, 3) == 0) ? PC_W'($urandom) : PC_W'($urandom_range(0, 7) * 7 + 2);
            cyc((n % 2 == 0) ? "R5" : "R4", pp, $urandom_range(0, 4) != 0, up, t,
                $urandom_range(0, 499) == 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule